// File: doc/BRIEF.md
# Token-Driven Instruction Field Fetch Selector

This block sits beside one processing element of a coarse-grained array and decides, cycle by cycle, which instruction fields that element must fetch from configuration storage. No instruction format is stored or read. Each upstream producer raises a one-bit token toward its consumers exactly one cycle before its data arrives. All tokens that belong to one instruction arrive together, so the block does not accumulate tokens over several cycles. It reads the token set present in the current cycle and turns it directly into a field-presence vector. That vector drives the fetch enables.

The block has a function-unit half and a register-file half. The function-unit half sees tokens from the mesh neighbours and from the register-file port. It uses the operand routing selects to decide which multiplexer-select fields are needed, and it needs the opcode and route fields whenever any token arrives. Every token it receives is also forwarded, through a register, toward the consumer directions named by the route setting. The register-file half enables the write-address field on a write token. It enables the read-address field on a read request, and it announces the read data one cycle later with its own token.

Top module: `tfd_format_disc`

## Requirements
- R1: While rst_ni is low, tok_o and rf_tok_o are zero, whatever the inputs are.
- R2: In a cycle with no bit of tok_i set and both rf_wr_tok_i and rf_rd_req_i low, fetch_en_o is all zero, and in the next cycle tok_o is zero.
- R3: When any bit of tok_i is set, fetch_en_o bit 0 (opcode field) and bit 3 (route field) are 1 in the same cycle. When no bit of tok_i is set, both are 0.
- R4: fetch_en_o bit 1 (operand-0 select field) is 1 in a cycle exactly when the tok_i bit indexed by src0_sel_i is set. A src0_sel_i value of N_IN or more selects no port and leaves the bit 0.
- R5: fetch_en_o bit 2 (operand-1 select field) follows the same rule using src1_sel_i.
- R6: tok_o in a cycle equals route_i from the previous cycle if that cycle had any tok_i bit set, and is zero otherwise.
- R7: fetch_en_o bit 4 (write-address field) equals rf_wr_tok_i in the same cycle.
- R8: fetch_en_o bit 5 (read-address field) equals rf_rd_req_i in the same cycle, and rf_tok_o equals rf_rd_req_i from the previous cycle.
- R9: Register-file requests on their own have no effect on fetch_en_o bits 0 to 3 or on tok_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_i | input | N_IN | Incoming tokens: mesh neighbours in the low bits, register-file port(s) in the high bits |
| src0_sel_i | input | SEL_W | Input port feeding operand 0 |
| src1_sel_i | input | SEL_W | Input port feeding operand 1 |
| route_i | input | N_MESH | Consumer directions for the outgoing tokens |
| rf_wr_tok_i | input | 1 | Write token for the register file |
| rf_rd_req_i | input | 1 | Read request to the register file |
| fetch_en_o | output | 6 | Field fetch enables: opcode, src0, src1, route, waddr, raddr (bits 0..5) |
| tok_o | output | N_MESH | Registered outgoing tokens per direction |
| rf_tok_o | output | 1 | Registered token announcing register-file read data |

## Verification
Directed patterns come first. An empty token set shows that nothing is fetched. A single token on each port in turn, with the operand selects both pointed at it and then away from it, separates the opcode enable from the operand enables. Out-of-range selects show that an invalid select matches no port. Cycles with only register-file requests show that the two halves are independent, and back-to-back token cycles with changing routes show the one-cycle forwarding. A long run of random token sets, selects and routes is then compared on every cycle against a behavioural model.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  localparam int FLD_OPC   = 0;
  localparam int FLD_SRC0  = 1;
  localparam int FLD_SRC1  = 2;
  localparam int FLD_ROUTE = 3;
  localparam int FLD_WADDR = 4;
  localparam int FLD_RADDR = 5;
  localparam int N_FLD     = 6;

  typedef logic [N_FLD-1:0] fld_vec_t;
endpackage

// File: rtl/tfd_fu_unit.sv
module tfd_fu_unit #(
  parameter int N_IN   = 5,
  parameter int SEL_W  = 3,
  parameter int N_OPND = 2
) (
  input  logic [N_IN-1:0]              tok_i,
  input  logic [N_OPND-1:0][SEL_W-1:0] sel_i,
  output logic                         fire_o,
  output logic [N_OPND-1:0]            opnd_en_o
);
  assign fire_o = |tok_i;

  // operand field needed only if its selected port carries a token
  for (genvar o = 0; o < N_OPND; o++) begin : g_opnd
    logic [N_IN-1:0] hit;
    for (genvar p = 0; p < N_IN; p++) begin : g_port
      assign hit[p] = tok_i[p] && (sel_i[o] == SEL_W'(p));
    end
    assign opnd_en_o[o] = |hit;
  end
endmodule

// File: rtl/tfd_rf_unit.sv
module tfd_rf_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_tok_i,
  input  logic rd_req_i,
  output logic en_waddr_o,
  output logic en_raddr_o,
  output logic rd_tok_o
);
  assign en_waddr_o = wr_tok_i;
  assign en_raddr_o = rd_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_tok_o <= 1'b0;
    else         rd_tok_o <= rd_req_i;
  end
endmodule

// File: rtl/tfd_tok_emit.sv
module tfd_tok_emit #(
  parameter int N_OUT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [N_OUT-1:0] route_i,
  output logic [N_OUT-1:0] tok_o
);
  for (genvar d = 0; d < N_OUT; d++) begin : g_dir
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tok_o[d] <= 1'b0;
      else         tok_o[d] <= fire_i & route_i[d];
    end
  end
endmodule

// File: rtl/tfd_format_disc.sv
module tfd_format_disc
  import tfd_pkg::*;
#(
  parameter int N_MESH     = 4,
  parameter int N_RF_PORTS = 1,
  parameter int N_IN       = N_MESH + N_RF_PORTS,
  parameter int SEL_W      = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   tok_i,
  input  logic [SEL_W-1:0]  src0_sel_i,
  input  logic [SEL_W-1:0]  src1_sel_i,
  input  logic [N_MESH-1:0] route_i,
  input  logic              rf_wr_tok_i,
  input  logic              rf_rd_req_i,
  output logic [N_FLD-1:0]  fetch_en_o,
  output logic [N_MESH-1:0] tok_o,
  output logic              rf_tok_o
);
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][SEL_W-1:0] sel;
  logic [N_OPND-1:0]            opnd_en;
  logic                         fire;
  logic                         en_waddr, en_raddr;
  fld_vec_t                     fmt;

  assign sel[0] = src0_sel_i;
  assign sel[1] = src1_sel_i;

  tfd_fu_unit #(.N_IN(N_IN), .SEL_W(SEL_W), .N_OPND(N_OPND)) u_fu (
    .tok_i     (tok_i),
    .sel_i     (sel),
    .fire_o    (fire),
    .opnd_en_o (opnd_en)
  );

  tfd_rf_unit u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_tok_i   (rf_wr_tok_i),
    .rd_req_i   (rf_rd_req_i),
    .en_waddr_o (en_waddr),
    .en_raddr_o (en_raddr),
    .rd_tok_o   (rf_tok_o)
  );

  tfd_tok_emit #(.N_OUT(N_MESH)) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .route_i (route_i),
    .tok_o   (tok_o)
  );

  always_comb begin
    fmt            = '0;
    fmt[FLD_OPC]   = fire;
    fmt[FLD_SRC0]  = opnd_en[0];
    fmt[FLD_SRC1]  = opnd_en[1];
    fmt[FLD_ROUTE] = fire;
    fmt[FLD_WADDR] = en_waddr;
    fmt[FLD_RADDR] = en_raddr;
  end

  assign fetch_en_o = fmt;
endmodule

// File: rtl/tfd_format_disc_chk.sv
module tfd_format_disc_chk
  import tfd_pkg::*;
#(
  parameter int N_MESH = 4,
  parameter int N_IN   = 5,
  parameter int SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IN-1:0]   tok_i,
  input logic [SEL_W-1:0]  src0_sel_i,
  input logic [SEL_W-1:0]  src1_sel_i,
  input logic [N_MESH-1:0] route_i,
  input logic              rf_wr_tok_i,
  input logic              rf_rd_req_i,
  input logic [N_FLD-1:0]  fetch_en_o,
  input logic [N_MESH-1:0] tok_o,
  input logic              rf_tok_o
);
  a_r2_idle_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_i == '0 && !rf_wr_tok_i && !rf_rd_req_i) |-> (fetch_en_o == '0));

  a_r2_idle_no_tok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_i == '0) |=> (tok_o == '0));

  a_r6_tok_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_i != '0) |=> (tok_o == $past(route_i)));

  a_r4_src0_needs_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o[FLD_SRC0] |-> fetch_en_o[FLD_OPC]);

  a_r5_src1_needs_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o[FLD_SRC1] |-> fetch_en_o[FLD_OPC]);

  a_r8_rf_rd_tok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_req_i |=> rf_tok_o);

  a_r7_waddr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_tok_i |-> fetch_en_o[FLD_WADDR]);

  a_r3_opc_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o[FLD_OPC] |-> fetch_en_o[FLD_ROUTE]);
endmodule

bind tfd_format_disc tfd_format_disc_chk #(
  .N_MESH(N_MESH), .N_IN(N_IN), .SEL_W(SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tok_i       (tok_i),
  .src0_sel_i  (src0_sel_i),
  .src1_sel_i  (src1_sel_i),
  .route_i     (route_i),
  .rf_wr_tok_i (rf_wr_tok_i),
  .rf_rd_req_i (rf_rd_req_i),
  .fetch_en_o  (fetch_en_o),
  .tok_o       (tok_o),
  .rf_tok_o    (rf_tok_o)
);

// File: tb/tfd_format_disc_tb_top.sv
`timescale 1ns/1ps
module tfd_format_disc_tb_top;
  localparam int N_MESH = 4;
  localparam int N_IN   = 5;
  localparam int SEL_W  = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_IN-1:0]   tok_i = '0;
  logic [SEL_W-1:0]  src0_sel_i = '0;
  logic [SEL_W-1:0]  src1_sel_i = '0;
  logic [N_MESH-1:0] route_i = '0;
  logic              rf_wr_tok_i = 1'b0;
  logic              rf_rd_req_i = 1'b0;
  logic [5:0]        fetch_en_o;
  logic [N_MESH-1:0] tok_o;
  logic              rf_tok_o;

  int checks = 0;
  int errors = 0;
  int exp_tok = 0;
  int exp_rf  = 0;

  always #2.5 clk_i = ~clk_i;

  tfd_format_disc dut_i (
    .clk_i, .rst_ni, .tok_i, .src0_sel_i, .src1_sel_i, .route_i,
    .rf_wr_tok_i, .rf_rd_req_i, .fetch_en_o, .tok_o, .rf_tok_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int t, input int s0, input int s1, input int rt,
                      input int wr, input int rd);
    int opc, b0, b1;
    @(negedge clk_i);
    chk("R6 tok_o", int'(tok_o), exp_tok);
    chk("R8 rf_tok_o", int'(rf_tok_o), exp_rf);
    tok_i = t[N_IN-1:0]; src0_sel_i = s0[SEL_W-1:0]; src1_sel_i = s1[SEL_W-1:0];
    route_i = rt[N_MESH-1:0]; rf_wr_tok_i = wr[0]; rf_rd_req_i = rd[0];
    #1;
    opc = (t != 0) ? 1 : 0;
    b0  = (s0 < N_IN) ? ((t >> s0) & 1) : 0;
    b1  = (s1 < N_IN) ? ((t >> s1) & 1) : 0;
    chk("R3 opcode", int'(fetch_en_o[0]), opc);
    chk("R3 route", int'(fetch_en_o[3]), opc);
    chk("R4 src0", int'(fetch_en_o[1]), b0);
    chk("R5 src1", int'(fetch_en_o[2]), b1);
    chk("R7 waddr", int'(fetch_en_o[4]), wr & 1);
    chk("R8 raddr", int'(fetch_en_o[5]), rd & 1);
    if (t == 0 && wr == 0 && rd == 0) chk("R2 idle fetch", int'(fetch_en_o), 0);
    if (t == 0 && (wr | rd) != 0) chk("R9 fu bits", int'(fetch_en_o[3:0]), 0);
    exp_tok = opc ? rt : 0;
    exp_rf  = rd & 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: busy inputs while in reset
    tok_i = '1; route_i = '1; rf_rd_req_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk("R1 tok_o in reset", int'(tok_o), 0);
      chk("R1 rf_tok_o in reset", int'(rf_tok_o), 0);
    end
    tok_i = '0; route_i = '0; rf_rd_req_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_tok = 0; exp_rf = 0;

    step(0, 0, 1, 4'hF, 0, 0);                 // R2 idle
    step(0, 0, 1, 4'h0, 0, 0);                 // R2 next cycle tok_o zero
    for (int p = 0; p < N_IN; p++) begin
      step(1 << p, p, p, 1 << (p % N_MESH), 0, 0);      // R4 R5 hit
      step(1 << p, (p + 1) % N_IN, (p + 2) % N_IN, 4'hA, 0, 0); // miss
    end
    step(5'h1F, 5, 6, 4'h3, 0, 0);             // R4 R5 out-of-range select
    step(5'h1F, 7, 7, 4'hC, 0, 0);
    step(0, 0, 0, 4'hF, 1, 0);                 // R9 rf only
    step(0, 0, 0, 4'hF, 0, 1);
    step(0, 0, 0, 4'hF, 1, 1);
    step(5'h03, 0, 1, 4'h5, 1, 1);
    step(5'h10, 4, 0, 4'h9, 0, 0);
    step(5'h0C, 2, 3, 4'h6, 0, 0);             // back-to-back R6
    step(5'h01, 0, 4, 4'h1, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++)
      step(int'($urandom_range(0, 31)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
    step(0, 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule